// File: doc/BRIEF.md
# Reset Configuration Word Sampler

This block captures the 32-bit configuration word that fixes the chip's initial operating mode after a hard reset. It watches the active-low hard-reset input. On the cycle that the release of hard reset is detected, it latches a word from one of three places. It takes the external data bus when the configuration-select input is high. It takes the non-volatile configuration register when the select input is low and that register is valid. It takes a built-in default constant in every other case.

The non-volatile source carries a blank flag. An erased flash reads this flag as 1, and that always forces the default word. The block also latches a 2-bit code that records which source was used. Its flash-enable output goes high by itself whenever the non-volatile word was chosen. Between hard-reset releases all three outputs hold their values, so soft resets elsewhere in the chip leave them alone.

The hard-reset and select inputs each pass through a synchronizer chain of parameterised depth. The bus word, the non-volatile word and the blank flag are treated as quasi-static at the moment of capture. A power-on reset clears everything.

Top module: `cfgsmp`

## Requirements
- R1: The outputs cfgWord, cfgSrc and flashEn change only on a detected low-to-high transition of the synchronized hard-reset input. Holding hard reset low or high, for any length of time, leaves them unchanged.
- R2: When the synchronized select input is 1 at the release, cfgWord takes busWord and cfgSrc becomes 2'b01.
- R3: When the synchronized select input is 0 at the release and nvmBlank is 0, cfgWord takes nvmWord and cfgSrc becomes 2'b10.
- R4: When the synchronized select input is 0 at the release and nvmBlank is 1, cfgWord becomes DEFAULT_WORD (0x0000_0000) and cfgSrc becomes 2'b00. This is the case of an erased flash.
- R5: flashEn is 1 exactly when cfgSrc is 2'b10, and it is updated in the same cycle as cfgWord.
- R6: If hrstN is first sampled high at clock edge m, the new word is visible after edge m + SYNC_STAGES, and the old word is still present after edge m + SYNC_STAGES - 1.
- R7: While porN is low, cfgWord is DEFAULT_WORD, cfgSrc is 2'b00 and flashEn is 0.
- R8: The select value used is the one sampled on the same clock edge as the first high hrstN sample. Changes on cfgSelBus, busWord, nvmWord or nvmBlank at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| hrstN | input | 1 | Hard reset, active low, asynchronous to clk |
| cfgSelBus | input | 1 | Configuration select: 1 takes the external bus |
| busWord | input | WORD_W | External data bus word |
| nvmWord | input | WORD_W | Non-volatile configuration register value |
| nvmBlank | input | 1 | Non-volatile validity flag, 1 when invalid or erased |
| cfgWord | output | WORD_W | Latched configuration word |
| cfgSrc | output | 2 | Source code: 00 default, 01 bus, 10 non-volatile |
| flashEn | output | 1 | Flash enable, high when the non-volatile word was used |

## Verification
The bench builds the block with WORD_W = 32 and SYNC_STAGES = 3 rather than the default of 2. This lets the latency check and the behavioural history model show that the capture point follows the synchronizer depth rather than a fixed two-cycle delay. The default word stays at zero, so the erased-flash case is checked against the value the requirements name. Single-cycle reset pulses, select flips on the release edge, and stimulus applied while reset is held all fall within the model's per-cycle comparison.

// File: rtl/cfgsmp_pkg.sv
package cfgsmp_pkg;

  typedef enum logic [1:0] {
    SRC_DEFAULT = 2'b00,
    SRC_BUS     = 2'b01,
    SRC_NVM     = 2'b10
  } cfgSrc_e;

  // strobes handed from control to datapath on the capture cycle
  typedef struct packed {
    logic capture;
    logic takeBus;
    logic takeNvm;
  } cfgStrobe_t;

endpackage

// File: rtl/cfgsmp_sync.sv
module cfgsmp_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic porN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) chain[0] <= RESET_VAL;
        else       chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) chain[i] <= RESET_VAL;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cfgsmp_ctrl.sv
module cfgsmp_ctrl
  import cfgsmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       hrstN,
  input  logic       cfgSelBus,
  input  logic       nvmBlank,
  output cfgStrobe_t stb
);

  logic hrstSync;
  logic selSync;
  logic hrstPrev;
  logic releaseSeen;

  cfgsmp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) hrstSync_i (
    .clk  (clk),
    .porN (porN),
    .d    (hrstN),
    .q    (hrstSync)
  );

  cfgsmp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) selSync_i (
    .clk  (clk),
    .porN (porN),
    .d    (cfgSelBus),
    .q    (selSync)
  );

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) hrstPrev <= 1'b0;
    else       hrstPrev <= hrstSync;
  end

  assign releaseSeen = hrstSync & ~hrstPrev;

  always_comb begin
    stb.capture = releaseSeen;
    stb.takeBus = releaseSeen & selSync;
    stb.takeNvm = releaseSeen & ~selSync & ~nvmBlank;
  end

endmodule

// File: rtl/cfgsmp_datapath.sv
module cfgsmp_datapath
  import cfgsmp_pkg::*;
#(
  parameter int                WORD_W       = 32,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = '0
) (
  input  logic              clk,
  input  logic              porN,
  input  cfgStrobe_t        stb,
  input  logic [WORD_W-1:0] busWord,
  input  logic [WORD_W-1:0] nvmWord,
  output logic [WORD_W-1:0] cfgWord,
  output cfgSrc_e           cfgSrc,
  output logic              flashEn
);

  logic [WORD_W-1:0] nextWord;
  cfgSrc_e           nextSrc;

  always_comb begin
    if (stb.takeBus) begin
      nextWord = busWord;
      nextSrc  = SRC_BUS;
    end else if (stb.takeNvm) begin
      nextWord = nvmWord;
      nextSrc  = SRC_NVM;
    end else begin
      nextWord = DEFAULT_WORD;
      nextSrc  = SRC_DEFAULT;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cfgWord <= DEFAULT_WORD;
      cfgSrc  <= SRC_DEFAULT;
      flashEn <= 1'b0;
    end else if (stb.capture) begin
      cfgWord <= nextWord;
      cfgSrc  <= nextSrc;
      flashEn <= stb.takeNvm;
    end
  end

endmodule

// File: rtl/cfgsmp.sv
module cfgsmp
  import cfgsmp_pkg::*;
#(
  parameter int                WORD_W       = 32,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = '0
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              hrstN,
  input  logic              cfgSelBus,
  input  logic [WORD_W-1:0] busWord,
  input  logic [WORD_W-1:0] nvmWord,
  input  logic              nvmBlank,
  output logic [WORD_W-1:0] cfgWord,
  output logic [1:0]        cfgSrc,
  output logic              flashEn
);

  cfgStrobe_t ctlStb;
  cfgSrc_e    srcCode;

  cfgsmp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk       (clk),
    .porN      (porN),
    .hrstN     (hrstN),
    .cfgSelBus (cfgSelBus),
    .nvmBlank  (nvmBlank),
    .stb       (ctlStb)
  );

  cfgsmp_datapath #(.WORD_W(WORD_W), .DEFAULT_WORD(DEFAULT_WORD)) dp_i (
    .clk     (clk),
    .porN    (porN),
    .stb     (ctlStb),
    .busWord (busWord),
    .nvmWord (nvmWord),
    .cfgWord (cfgWord),
    .cfgSrc  (srcCode),
    .flashEn (flashEn)
  );

  assign cfgSrc = srcCode;

endmodule

// File: rtl/cfgsmp_chk.sv
module cfgsmp_chk
  import cfgsmp_pkg::*;
#(
  parameter int                WORD_W       = 32,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = '0
) (
  input logic              clk,
  input logic              porN,
  input cfgStrobe_t        ctlStb,
  input logic              nvmBlank,
  input logic [WORD_W-1:0] busWord,
  input logic [WORD_W-1:0] nvmWord,
  input logic [WORD_W-1:0] cfgWord,
  input logic [1:0]        cfgSrc,
  input logic              flashEn
);

  AST_HOLD_WITHOUT_RELEASE: assert property (@(posedge clk) disable iff (!porN)
    !ctlStb.capture |=> ($stable(cfgWord) && $stable(cfgSrc) && $stable(flashEn))); // R1

  AST_BUS_TAKEN: assert property (@(posedge clk) disable iff (!porN)
    (ctlStb.capture && ctlStb.takeBus) |=> (cfgWord == $past(busWord) && cfgSrc == 2'b01)); // R2

  AST_NVM_TAKEN: assert property (@(posedge clk) disable iff (!porN)
    (ctlStb.capture && !ctlStb.takeBus && !nvmBlank) |=> (cfgWord == $past(nvmWord) && cfgSrc == 2'b10)); // R3

  AST_DEFAULT_TAKEN: assert property (@(posedge clk) disable iff (!porN)
    (ctlStb.capture && !ctlStb.takeBus && nvmBlank) |=> (cfgWord == DEFAULT_WORD && cfgSrc == 2'b00)); // R4

  AST_FLASH_MATCHES_SRC: assert property (@(posedge clk) disable iff (!porN)
    flashEn == (cfgSrc == 2'b10)); // R5

  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!porN)
    $onehot0({ctlStb.takeBus, ctlStb.takeNvm})); // R2

  AST_TAKE_ONLY_AT_RELEASE: assert property (@(posedge clk) disable iff (!porN)
    (ctlStb.takeBus || ctlStb.takeNvm) |-> ctlStb.capture); // R8

endmodule

bind cfgsmp cfgsmp_chk #(.WORD_W(WORD_W), .DEFAULT_WORD(DEFAULT_WORD)) chk_i (
  .clk      (clk),
  .porN     (porN),
  .ctlStb   (ctlStb),
  .nvmBlank (nvmBlank),
  .busWord  (busWord),
  .nvmWord  (nvmWord),
  .cfgWord  (cfgWord),
  .cfgSrc   (cfgSrc),
  .flashEn  (flashEn)
);

// File: tb/cfgsmp_tb_top.sv
module cfgsmp_tb_top;

  localparam int          W    = 32;
  localparam int          S    = 3;
  localparam logic [W-1:0] DEFW = '0;

  logic         clk = 1'b0;
  logic         porN = 1'b0;
  logic         hrstN = 1'b0;
  logic         cfgSelBus = 1'b0;
  logic [W-1:0] busWord = '0;
  logic [W-1:0] nvmWord = '0;
  logic         nvmBlank = 1'b1;
  logic [W-1:0] cfgWord;
  logic [1:0]   cfgSrc;
  logic         flashEn;

  int    vectors = 0;
  int    misses  = 0;
  bit    done    = 1'b0;
  string curTag  = "R7";

  always #4 clk = ~clk;  // 125 MHz

  cfgsmp #(.WORD_W(W), .SYNC_STAGES(S), .DEFAULT_WORD(DEFW)) dut_i (
    .clk       (clk),
    .porN      (porN),
    .hrstN     (hrstN),
    .cfgSelBus (cfgSelBus),
    .busWord   (busWord),
    .nvmWord   (nvmWord),
    .nvmBlank  (nvmBlank),
    .cfgWord   (cfgWord),
    .cfgSrc    (cfgSrc),
    .flashEn   (flashEn)
  );

  // behavioural reference: input history, newest first
  int           histH[0:15];
  int           histS[0:15];
  logic [W-1:0] mWord;
  logic [1:0]   mSrc;
  logic         mFlash;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int k = 0; k < 16; k++) begin histH[k] = 0; histS[k] = 0; end
      mWord = DEFW; mSrc = 2'b00; mFlash = 1'b0;
    end else begin
      if (histH[S-1] == 1 && histH[S] == 0) begin
        if (histS[S-1] == 1) begin
          mWord = busWord; mSrc = 2'b01; mFlash = 1'b0;
        end else if (!nvmBlank) begin
          mWord = nvmWord; mSrc = 2'b10; mFlash = 1'b1;
        end else begin
          mWord = DEFW; mSrc = 2'b00; mFlash = 1'b0;
        end
      end
      for (int k = 15; k > 0; k--) begin histH[k] = histH[k-1]; histS[k] = histS[k-1]; end
      histH[0] = int'(hrstN);
      histS[0] = int'(cfgSelBus);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (cfgWord !== mWord || cfgSrc !== mSrc || flashEn !== mFlash) begin
        misses++;
        $display("FAIL %s model: word=%h src=%b fl=%b expected word=%h src=%b fl=%b",
                 curTag, cfgWord, cfgSrc, flashEn, mWord, mSrc, mFlash);
      end
    end
  end

  task automatic expectNow(string tag, logic [W-1:0] w, logic [1:0] s, logic f);
    vectors++;
    if (cfgWord !== w || cfgSrc !== s || flashEn !== f) begin
      misses++;
      $display("FAIL %s: word=%h src=%b fl=%b expected word=%h src=%b fl=%b",
               tag, cfgWord, cfgSrc, flashEn, w, s, f);
    end
  endtask

  task automatic stepDrive(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulseReset(int lowCycles);
    stepDrive(1); hrstN = 1'b0;
    stepDrive(lowCycles); hrstN = 1'b1;
  endtask

  initial begin
    // R7: power-on state
    repeat (2) @(negedge clk);
    expectNow("R7", DEFW, 2'b00, 1'b0);
    stepDrive(2); porN = 1'b1;

    // R1 / R8: stimulus while hard reset is held low
    curTag = "R1";
    for (int i = 0; i < 10; i++) begin
      stepDrive(1);
      busWord = 32'hDEAD_0000 + W'(i); nvmWord = ~busWord;
      cfgSelBus = i[0]; nvmBlank = i[1];
    end
    @(negedge clk);
    expectNow("R1", DEFW, 2'b00, 1'b0);

    // R2 / R6: bus source and latency
    curTag = "R2";
    stepDrive(1); cfgSelBus = 1'b1; busWord = 32'hA5A5_0F0F; nvmBlank = 1'b0;
    stepDrive(S + 2); hrstN = 1'b1;
    repeat (S + 1) @(negedge clk);
    expectNow("R6", DEFW, 2'b00, 1'b0);
    @(negedge clk);
    expectNow("R2", 32'hA5A5_0F0F, 2'b01, 1'b0);

    // R8: inputs move while reset stays high
    curTag = "R8";
    for (int i = 0; i < 8; i++) begin
      stepDrive(1); busWord = 32'h1111_1111 * W'(i); cfgSelBus = ~cfgSelBus; nvmBlank = ~nvmBlank;
    end
    @(negedge clk);
    expectNow("R8", 32'hA5A5_0F0F, 2'b01, 1'b0);

    // R3 / R5: non-volatile source
    curTag = "R3";
    stepDrive(1); hrstN = 1'b0; cfgSelBus = 1'b0; nvmBlank = 1'b0; nvmWord = 32'h1234_5678;
    stepDrive(4);
    @(negedge clk);
    expectNow("R1", 32'hA5A5_0F0F, 2'b01, 1'b0);
    stepDrive(1); hrstN = 1'b1;
    repeat (S + 3) @(negedge clk);
    expectNow("R3", 32'h1234_5678, 2'b10, 1'b1);
    expectNow("R5", 32'h1234_5678, 2'b10, 1'b1);

    // R4: erased flash forces default
    curTag = "R4";
    stepDrive(1); nvmBlank = 1'b1; nvmWord = 32'hFFFF_FFFF;
    pulseReset(3);
    repeat (S + 3) @(negedge clk);
    expectNow("R4", DEFW, 2'b00, 1'b0);
    expectNow("R5", DEFW, 2'b00, 1'b0);

    // R8: select flips on the release edge itself
    curTag = "R8";
    stepDrive(1); hrstN = 1'b0; cfgSelBus = 1'b1; nvmBlank = 1'b0; nvmWord = 32'hCAFE_F00D;
    busWord = 32'h0BAD_BEEF;
    stepDrive(3); hrstN = 1'b1; cfgSelBus = 1'b0;
    repeat (S + 3) @(negedge clk);
    expectNow("R8", 32'hCAFE_F00D, 2'b10, 1'b1);

    // R1: one-cycle reset pulse still yields a capture
    curTag = "R1";
    stepDrive(1); cfgSelBus = 1'b1; busWord = 32'h5555_AAAA;
    stepDrive(S + 1);
    pulseReset(1);
    repeat (S + 3) @(negedge clk);
    expectNow("R1", 32'h5555_AAAA, 2'b01, 1'b0);

    // mixed patterns, checked by the model every cycle
    curTag = "R2";
    for (int i = 0; i < 30; i++) begin
      stepDrive(1);
      busWord   = 32'h9E37_79B9 * W'(i + 1);
      nvmWord   = 32'h7F4A_7C15 ^ (busWord << 3);
      cfgSelBus = busWord[5];
      nvmBlank  = busWord[9];
      pulseReset(1 + (i % 4));
      stepDrive(S + 1 + (i % 3));
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule